// File: doc/BRIEF.md
# Burst-Drain Byte Bridge to Serial Transmitter

This block matches a fast byte source to a slow asynchronous serial transmit line. Bytes arrive on a write port with a valid strobe and are stored in an internal FIFO. The FIFO exposes active-low full and empty flags to both the source-side flow control and the serial reader. The flow control has hysteresis between full and empty. When the FIFO fills, a pause request goes to the source, and it stays up until the FIFO has been completely emptied. Meanwhile the serial side waits for a full FIFO, then sends bytes back to back until the FIFO is empty.

An expected byte total is given as an input and held steady while out of reset. Once that many bytes have been accepted, the serial side flushes whatever is left, even if the FIFO never filled. The block then raises a done flag and stays stopped until the next reset. Each byte leaves as one 8N1 frame: a low start bit, eight data bits with the least significant bit first, and a high stop bit. Every bit lasts a fixed number of clock cycles set by a parameter.

Top module: `burst_bridge`

## Requirements
- R1: While reset is active, the serial line is high, the pause request is low and the done flag is low.
- R2: A byte is accepted on a clock edge only when the valid strobe is high, the pause request is low and fewer than the expected total have been accepted so far. Any other strobe has no effect.
- R3: The pause request is high in every cycle in which the FIFO holds DEPTH bytes. It stays high until the FIFO is empty and falls on the first clock edge after the FIFO becomes empty.
- R4: A serial frame starts only while a drain burst is in progress, or after the full expected total has been accepted. A drain burst begins on the edge after the FIFO was seen full and ends once the FIFO was seen empty.
- R5: The serial line idles high. A frame is a low start bit, then data bits 0 to 7 in that order, then a high stop bit, each lasting BAUD_DIV clock cycles.
- R6: Bytes leave on the serial line in the order they were accepted, with none lost and none repeated.
- R7: Once the expected total has been accepted, the remaining bytes are sent. The done flag rises only when the FIFO is empty and the last frame, including its stop bit, has finished.
- R8: The done flag stays high until reset. While it is high, no byte is accepted and the serial line stays high.
- R9: With an expected total of zero, the done flag rises shortly after reset without any frame being sent.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_valid | input | 1 | Byte strobe from the source |
| wr_data | input | DATA_W | Byte from the source |
| total_bytes | input | CNT_W | Expected number of bytes, held steady out of reset |
| uart_tx | output | 1 | Serial transmit line, 8N1 |
| pause | output | 1 | Request to the source to stop sending |
| done | output | 1 | All bytes received and sent, sticky |

## Verification
Several properties are checked on every cycle:
- no push into a full FIFO and no pop from an empty one;
- the pause request one cycle after full;
- a start bit at the beginning of every frame and a high idle line;
- the done flag is sticky and the FIFO is empty while done is high.

Other behaviours only show up across whole scenarios:
- burst-only draining against a model of FIFO occupancy;
- release of the pause one edge after a drain;
- byte order and 8N1 framing as decoded from the line;
- the final flush when the total is smaller than, equal to or larger than the FIFO depth, and the zero-total case.

// File: rtl/bb_pkg.sv
package bb_pkg;
  localparam int BYTE_W     = 8;
  localparam int EXTRA_BITS = 2;   // start and stop bit around the data
endpackage

// File: rtl/bb_fifo.sv
module bb_fifo #(
  parameter int DATA_W = 8,
  parameter int DEPTH  = 1024
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              push,
  input  logic [DATA_W-1:0] push_data,
  input  logic              pop,
  output logic [DATA_W-1:0] pop_data,
  output logic              full_n,
  output logic              empty_n
);
  localparam int AW = $clog2(DEPTH);

  logic [DATA_W-1:0] mem [DEPTH];
  logic [AW:0] wr_q, wr_d, rd_q, rd_d;

  always_comb begin
    wr_d = wr_q;
    rd_d = rd_q;
    if (push) wr_d = wr_q + 1'b1;
    if (pop)  rd_d = rd_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_q <= '0;
      rd_q <= '0;
    end else begin
      wr_q <= wr_d;
      rd_q <= rd_d;
    end
  end

  always_ff @(posedge clk) begin
    if (push) mem[wr_q[AW-1:0]] <= push_data;
  end

  assign pop_data = mem[rd_q[AW-1:0]];
  assign empty_n  = (wr_q != rd_q);
  assign full_n   = !((wr_q[AW] != rd_q[AW]) && (wr_q[AW-1:0] == rd_q[AW-1:0]));

  a_r2_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    push |-> full_n);
  a_r6_no_underflow: assert property (@(posedge clk) disable iff (!rst_n)
    pop |-> empty_n);
endmodule

// File: rtl/bb_flow.sv
module bb_flow #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_valid,
  input  logic [CNT_W-1:0] total,
  input  logic             full_n,
  input  logic             empty_n,
  input  logic             tx_ready,
  output logic             push,
  output logic             pop,
  output logic             pause,
  output logic             done
);
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic burst_q, burst_d;
  logic done_q, done_d;
  logic all_in;

  assign all_in = (cnt_q == total);
  assign pause  = burst_q | ~full_n;
  assign push   = wr_valid & ~pause & ~all_in & ~done_q;
  assign pop    = (burst_q | all_in) & empty_n & tx_ready & ~done_q;
  assign done   = done_q;

  always_comb begin
    cnt_d = cnt_q;
    if (push) cnt_d = cnt_q + 1'b1;
    burst_d = burst_q;
    if (!full_n)       burst_d = 1'b1;
    else if (!empty_n) burst_d = 1'b0;
    done_d = done_q | (all_in & ~empty_n & tx_ready);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      burst_q <= 1'b0;
      done_q  <= 1'b0;
    end else begin
      cnt_q   <= cnt_d;
      burst_q <= burst_d;
      done_q  <= done_d;
    end
  end

  a_r3_pause_after_full: assert property (@(posedge clk) disable iff (!rst_n)
    !full_n |=> pause);
  a_r8_done_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> done);
  a_r7_done_empty: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !empty_n);
endmodule

// File: rtl/bb_uart_tx.sv
module bb_uart_tx #(
  parameter int DATA_W   = 8,
  parameter int BAUD_DIV = 2604
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [DATA_W-1:0] data,
  output logic              ready,
  output logic              line
);
  localparam int NBITS = DATA_W + bb_pkg::EXTRA_BITS;
  localparam int CW    = $clog2(NBITS + 1);
  localparam int BCW   = (BAUD_DIV > 1) ? $clog2(BAUD_DIV) : 1;

  logic [BCW-1:0]  baud_q, baud_d;
  logic [CW-1:0]   bit_q, bit_d;
  logic [DATA_W:0] sh_q, sh_d;
  logic            busy_q, busy_d;
  logic            line_q, line_d;
  logic            tick;

  assign tick  = (baud_q == BCW'(BAUD_DIV - 1));
  assign ready = ~busy_q;
  assign line  = line_q;

  always_comb begin
    baud_d = baud_q;
    bit_d  = bit_q;
    sh_d   = sh_q;
    busy_d = busy_q;
    line_d = line_q;
    if (!busy_q) begin
      line_d = 1'b1;
      if (load) begin
        busy_d = 1'b1;
        line_d = 1'b0;
        sh_d   = {1'b1, data};
        bit_d  = '0;
        baud_d = '0;
      end
    end else if (tick) begin
      baud_d = '0;
      if (bit_q == CW'(NBITS - 1)) begin
        busy_d = 1'b0;
        line_d = 1'b1;
      end else begin
        line_d = sh_q[0];
        sh_d   = {1'b1, sh_q[DATA_W:1]};
        bit_d  = bit_q + 1'b1;
      end
    end else begin
      baud_d = baud_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      baud_q <= '0;
      bit_q  <= '0;
      sh_q   <= '1;
      busy_q <= 1'b0;
      line_q <= 1'b1;
    end else begin
      baud_q <= baud_d;
      bit_q  <= bit_d;
      sh_q   <= sh_d;
      busy_q <= busy_d;
      line_q <= line_d;
    end
  end

  a_r5_idle_high: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_q |-> line_q);
  a_r5_start_low: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && !$past(busy_q)) |-> !line_q);
  a_r4_load_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
    load |-> !busy_q);
endmodule

// File: rtl/burst_bridge.sv
module burst_bridge #(
  parameter int DATA_W   = bb_pkg::BYTE_W,
  parameter int DEPTH    = 1024,
  parameter int BAUD_DIV = 2604,
  parameter int CNT_W    = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_valid,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [CNT_W-1:0]  total_bytes,
  output logic              uart_tx,
  output logic              pause,
  output logic              done
);
  logic push, pop, full_n, empty_n, tx_ready;
  logic [DATA_W-1:0] head;

  bb_fifo #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_fifo (
    .clk(clk), .rst_n(rst_n), .push(push), .push_data(wr_data),
    .pop(pop), .pop_data(head), .full_n(full_n), .empty_n(empty_n)
  );

  bb_flow #(.CNT_W(CNT_W)) u_flow (
    .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .total(total_bytes),
    .full_n(full_n), .empty_n(empty_n), .tx_ready(tx_ready),
    .push(push), .pop(pop), .pause(pause), .done(done)
  );

  bb_uart_tx #(.DATA_W(DATA_W), .BAUD_DIV(BAUD_DIV)) u_tx (
    .clk(clk), .rst_n(rst_n), .load(pop), .data(head),
    .ready(tx_ready), .line(uart_tx)
  );

  a_r8_idle_when_done: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> uart_tx);
endmodule

// File: tb/test_burst_bridge.sv
module test_burst_bridge;
  localparam int DEPTH = 8;
  localparam int B     = 4;
  localparam int CW    = 16;

  logic clk = 1'b0;
  logic rst_n;
  logic wr_valid;
  logic [7:0] wr_data;
  logic [CW-1:0] total_bytes;
  logic uart_tx, pause, done;

  always #5 clk = ~clk;

  burst_bridge #(.DATA_W(8), .DEPTH(DEPTH), .BAUD_DIV(B), .CNT_W(CW)) i_burst_bridge (
    .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_data(wr_data),
    .total_bytes(total_bytes), .uart_tx(uart_tx), .pause(pause), .done(done)
  );

  int total = 0, bad = 0;
  logic [7:0] exp_q[$];
  int occ, acc, started, rx_ctr;
  bit drain_m, in_frame, prev_tx, pend, done_seen;
  logic [7:0] rx_byte;

  task automatic check(input bit ok, input string req, input int act, input int expv);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, expv, $time);
    end
  endtask

  task automatic do_reset(input int tot);
    rst_n = 1'b0;
    wr_valid = 1'b0;
    wr_data = '0;
    total_bytes = CW'(tot);
    repeat (3) @(negedge clk);
    check(uart_tx == 1'b1, "R1 line", uart_tx, 1);
    check(pause == 1'b0, "R1 pause", pause, 0);
    check(done == 1'b0, "R1 done", done, 0);
    exp_q.delete();
    occ = 0; acc = 0; started = 0; rx_ctr = 0;
    drain_m = 0; in_frame = 0; prev_tx = 1; pend = 0; done_seen = 0;
    rst_n = 1'b1;
  endtask

  task automatic run_case(input int tot, input int prob);
    int cyc = 0, extra = 0, acc_before;
    bit prev_drain;
    do_reset(tot);
    while (!(done_seen && extra >= 40)) begin
      @(negedge clk);
      cyc++;
      acc_before = acc;
      if (pend) begin occ++; acc++; end
      if (!in_frame && prev_tx && !uart_tx) begin
        // R4: frame starts only in a burst or during the final flush
        check(drain_m || acc_before == tot, "R4 start outside burst", occ, DEPTH);
        in_frame = 1; rx_ctr = 0; occ--; started++;
      end else if (in_frame) begin
        rx_ctr++;
        if (rx_ctr % B == 0) begin
          if (rx_ctr / B <= 8) rx_byte[rx_ctr / B - 1] = uart_tx;
          else begin
            check(uart_tx == 1'b1, "R5 stop bit", uart_tx, 1);
            if (exp_q.size() == 0) check(0, "R6 extra byte", rx_byte, 0);
            else begin
              logic [7:0] e;
              e = exp_q.pop_front();
              check(rx_byte == e, "R6 byte order", rx_byte, e);
            end
            in_frame = 0;
          end
        end
      end
      prev_drain = drain_m;
      if (occ == DEPTH) drain_m = 1;
      else if (occ == 0) drain_m = 0;
      if (occ == DEPTH) check(pause == 1'b1, "R3 pause on full", pause, 1);
      else if (!prev_drain && !drain_m && acc < tot)
        check(pause == 1'b0, "R3 resume after drain", pause, 0);
      if (done && !done_seen) begin
        done_seen = 1;
        check(acc == tot && occ == 0 && !in_frame && started == tot,
              tot == 0 ? "R9 zero total" : "R7 done timing", started, tot);
      end
      if (done_seen) begin
        extra++;
        check(done == 1'b1, "R8 done sticky", done, 1);
        check(uart_tx == 1'b1, "R8 line idle", uart_tx, 1);
      end
      wr_valid = done_seen ? 1'b1 : (($urandom % 100) < prob);
      wr_data = 8'($urandom);
      pend = wr_valid && !pause && acc < tot;
      if (pend) exp_q.push_back(wr_data);
      prev_tx = uart_tx;
      if (cyc > 20000) begin
        check(0, "R7 watchdog", cyc, 20000);
        break;
      end
    end
    // R2: strobes after the total never reached the line
    check(started == tot && acc == tot, "R2 accepted count", started, tot);
  endtask

  initial begin
    void'($urandom(32'd1357));
    run_case(37, 70);
    run_case(DEPTH, 100);
    run_case(5, 50);
    run_case(0, 100);
    run_case(20, 15);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule